// File: doc/BRIEF.md
# Pixel Readout Phase Sequencer

This block drives the control phases of one pixel readout channel for one pulse. The arrival time of each pulse is known in advance, so an external pulse trigger starts the sequence. No detected signal starts it. A cycle always runs the same five phases in this order:

- a sensor clear,
- a baseline integration,
- a settling interval,
- a signal integration with inverted sign,
- a hold interval in which the converter digitizes the filtered difference.

A separate one-cycle flip strobe marks the moment when the integration sign reverses, between the two integrations.

The integration windows grow with the pulse period. A rate selector picks one of three window sets, with all lengths counted in cycles of a 1 ns reference clock:

| Rate | Period | Cycles |
|---|---|---|
| 5 MHz | 200 ns | 200 |
| 2.5 MHz | 400 ns | 400 |
| 1 MHz | 1 us | 1000 |

The selector is sampled only when a trigger is accepted, so a rate change never distorts a cycle that is already running. A trigger that arrives while a cycle is still running is dropped and raises a sticky overrun flag. A trigger in the very last hold cycle is accepted, so pulses can follow each other back to back at the full rate.

Top module: `pxseq_top`

## Requirements
- R1: While reset is held and in the first cycle after it, only the idle strobe is high, the flip strobe is low and the overrun flag is low.
- R2: In every cycle after reset exactly one bit of `phase_o` is high. The bit positions are: 0 idle, 1 clear, 2 baseline, 3 settle, 4 signal, 5 hold. A cycle always visits clear, baseline, settle, signal and hold in that order and then returns to idle.
- R3: When `en_i` and `trig_i` are both high in an idle cycle, clear starts in the next cycle. The `rate_sel_i` encoding is: 0 selects 5 MHz, 1 selects 2.5 MHz, 2 selects 1 MHz, and 3 behaves exactly like 0.
- R4: At 5 MHz the phases last 20, 65, 30, 65 and 20 cycles, for 200 cycles in total.
- R5: At 2.5 MHz the phases last 20, 165, 30, 165 and 20 cycles, for 400 cycles in total.
- R6: At 1 MHz the phases last 20, 435, 30, 435 and 80 cycles, for 1000 cycles in total.
- R7: `flip_o` is high for exactly one cycle per readout cycle. That cycle is the last settle cycle, and signal follows directly after it.
- R8: An enabled trigger during any busy cycle other than the last hold cycle has no effect on the running sequence. It sets `overrun_o`, which then stays high until reset.
- R9: An enabled trigger in the last hold cycle starts a new clear in the next cycle, with no idle cycle in between, and does not set `overrun_o`.
- R10: `rate_sel_i` is sampled only when a trigger is accepted. A change during a running cycle does not alter that cycle's windows.
- R11: While `en_i` is low, triggers are ignored and do not set `overrun_o`. A cycle that is already running completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, 1 ns per cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Allows triggers to start cycles |
| trig_i | input | 1 | Pulse trigger, aligned to the known pulse time |
| rate_sel_i | input | 2 | Rate choice: 0 = 5 MHz, 1 = 2.5 MHz, 2 = 1 MHz, 3 = 5 MHz |
| phase_o | output | 6 | One-hot phase strobes: idle, clear, baseline, settle, signal, hold |
| flip_o | output | 1 | One-cycle integration sign-flip strobe |
| overrun_o | output | 1 | Sticky flag for a trigger that arrived during a busy cycle |

## Verification
`phase_o`, `flip_o` and `overrun_o` are all decoded from registers. An accepted trigger therefore shows up as clear one cycle after the edge that samples it, and an early trigger shows up on `overrun_o` one cycle later.

The bench drives its inputs and samples the outputs on the falling edge. It raises the trigger for one cycle and starts counting at the first clear cycle. It then compares every cycle of the cycle against an expected window table that it holds itself, so each phase length is checked to the exact cycle. Mid-cycle triggers are placed at a known cycle index, which lets the back-to-back case be checked at precisely the last hold cycle.

// File: rtl/pxseq_pkg.sv
package pxseq_pkg;

    localparam int LEN_W      = 10;
    localparam int NUM_PHASES = 6;
    localparam int PH_W       = 3;
    localparam int NUM_RATES  = 4;

    typedef enum logic [PH_W-1:0] {
        PH_IDLE   = 3'd0,
        PH_CLEAR  = 3'd1,
        PH_BASE   = 3'd2,
        PH_SETTLE = 3'd3,
        PH_SIGNAL = 3'd4,
        PH_HOLD   = 3'd5
    } phase_e;

    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        len_t clr;
        len_t base;
        len_t settle;
        len_t sig;
        len_t hold;
    } win_t;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_CLEAR:  return PH_BASE;
            PH_BASE:   return PH_SETTLE;
            PH_SETTLE: return PH_SIGNAL;
            PH_SIGNAL: return PH_HOLD;
            default:   return PH_IDLE;
        endcase
    endfunction

    function automatic len_t phase_len(input phase_e p, input win_t w);
        case (p)
            PH_CLEAR:  return w.clr;
            PH_BASE:   return w.base;
            PH_SETTLE: return w.settle;
            PH_SIGNAL: return w.sig;
            PH_HOLD:   return w.hold;
            default:   return '0;
        endcase
    endfunction

endpackage

// File: rtl/pxseq_win_table.sv
module pxseq_win_table
    import pxseq_pkg::*;
#(
    parameter int CLR_CYC   = 20,
    parameter int SETL_CYC  = 30,
    parameter int INT_FAST  = 65,
    parameter int INT_MID   = 165,
    parameter int INT_SLOW  = 435,
    parameter int HOLD_FAST = 20,
    parameter int HOLD_SLOW = 80
) (
    input  logic [1:0] rate_i,
    output win_t       win_o
);

    win_t entry [NUM_RATES];

    function automatic int integ_for(input int r);
        if (r == 1) return INT_MID;
        if (r == 2) return INT_SLOW;
        return INT_FAST;
    endfunction

    function automatic int hold_for(input int r);
        return (r == 2) ? HOLD_SLOW : HOLD_FAST;
    endfunction

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign entry[g].clr    = LEN_W'(CLR_CYC);
        assign entry[g].base   = LEN_W'(integ_for(g));
        assign entry[g].settle = LEN_W'(SETL_CYC);
        assign entry[g].sig    = LEN_W'(integ_for(g));
        assign entry[g].hold   = LEN_W'(hold_for(g));
    end

    assign win_o = entry[rate_i];

endmodule

// File: rtl/pxseq_ctrl.sv
module pxseq_ctrl
    import pxseq_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   start_i,
    input  win_t   win_i,
    output phase_e phase_o,
    output logic   last_o,
    output logic   flip_o
);

    phase_e ph_q;
    len_t   cnt_q;
    win_t   win_q;
    phase_e ph_nxt;
    len_t   nxt_len;

    assign ph_nxt  = next_phase(ph_q);
    assign nxt_len = phase_len(ph_nxt, win_q);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            win_q <= '0;
        end else if (start_i) begin
            ph_q  <= PH_CLEAR;
            cnt_q <= win_i.clr - LEN_W'(1);
            win_q <= win_i;
        end else if (ph_q != PH_IDLE) begin
            if (cnt_q == '0) begin
                ph_q  <= ph_nxt;
                cnt_q <= (ph_nxt == PH_IDLE) ? '0 : nxt_len - LEN_W'(1);
            end else begin
                cnt_q <= cnt_q - LEN_W'(1);
            end
        end
    end

    assign phase_o = ph_q;
    assign last_o  = (ph_q != PH_IDLE) && (cnt_q == '0);
    assign flip_o  = (ph_q == PH_SETTLE) && (cnt_q == '0);

    AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (ph_q == PH_CLEAR && cnt_q == win_q.clr - LEN_W'(1))); // R3
    AST_FLIP_THEN_SIGNAL: assert property (@(posedge clk_i) disable iff (rst_i)
        (flip_o && !start_i) |=> (ph_q == PH_SIGNAL)); // R7
    AST_FLIP_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        flip_o |=> !flip_o); // R7
    AST_WIN_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (ph_q != PH_IDLE && !start_i) |=> $stable(win_q)); // R10

endmodule

// File: rtl/pxseq_trig_gate.sv
module pxseq_trig_gate
    import pxseq_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   en_i,
    input  logic   trig_i,
    input  phase_e phase_i,
    input  logic   last_i,
    output logic   start_o,
    output logic   overrun_o
);

    logic req;
    logic can_take;
    logic ovr_q;

    assign req      = en_i && trig_i;
    assign can_take = (phase_i == PH_IDLE) || (phase_i == PH_HOLD && last_i);
    assign start_o  = req && can_take;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            ovr_q <= 1'b0;
        else if (req && !can_take)
            ovr_q <= 1'b1;
    end

    assign overrun_o = ovr_q;

    AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        overrun_o |=> overrun_o); // R8
    AST_OVR_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
        (!overrun_o && !en_i) |=> !overrun_o); // R11

endmodule

// File: rtl/pxseq_phase_dec.sv
module pxseq_phase_dec
    import pxseq_pkg::*;
(
    input  phase_e                  phase_i,
    output logic [NUM_PHASES-1:0]   strobe_o
);

    logic [PH_W-1:0] ph_bits;
    assign ph_bits = phase_i;

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_strobe
        assign strobe_o[g] = (ph_bits == PH_W'(g));
    end

endmodule

// File: rtl/pxseq_top.sv
module pxseq_top
    import pxseq_pkg::*;
#(
    parameter int CLR_CYC   = 20,
    parameter int SETL_CYC  = 30,
    parameter int INT_FAST  = 65,
    parameter int INT_MID   = 165,
    parameter int INT_SLOW  = 435,
    parameter int HOLD_FAST = 20,
    parameter int HOLD_SLOW = 80
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       en_i,
    input  logic       trig_i,
    input  logic [1:0] rate_sel_i,
    output logic [5:0] phase_o,
    output logic       flip_o,
    output logic       overrun_o
);

    win_t   win;
    phase_e phase;
    logic   last;
    logic   start;

    pxseq_win_table #(
        .CLR_CYC(CLR_CYC), .SETL_CYC(SETL_CYC), .INT_FAST(INT_FAST),
        .INT_MID(INT_MID), .INT_SLOW(INT_SLOW),
        .HOLD_FAST(HOLD_FAST), .HOLD_SLOW(HOLD_SLOW)
    ) u_table (
        .rate_i (rate_sel_i),
        .win_o  (win)
    );

    pxseq_trig_gate u_gate (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .en_i      (en_i),
        .trig_i    (trig_i),
        .phase_i   (phase),
        .last_i    (last),
        .start_o   (start),
        .overrun_o (overrun_o)
    );

    pxseq_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start),
        .win_i   (win),
        .phase_o (phase),
        .last_o  (last),
        .flip_o  (flip_o)
    );

    pxseq_phase_dec u_dec (
        .phase_i  (phase),
        .strobe_o (phase_o)
    );

    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(phase_o) == 1); // R2
    AST_SIGNAL_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(phase_o[4]) |-> $past(phase_o[3])); // R2
    AST_EARLY_TRIG_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && trig_i && phase_o[2]) |=> (overrun_o && phase_o[2] || phase_o[3])); // R8
    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && phase_o[0]) |=> phase_o[0]); // R11

endmodule

// File: tb/sim_pxseq_top.sv
`timescale 1ns/1ps
module sim_pxseq_top;

    localparam int CLK_NS = 10;
    localparam int WD_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       trig = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic [5:0] phase_o;
    logic       flip_o;
    logic       overrun_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    pxseq_top u0 (
        .clk_i(clk), .rst_i(rst), .en_i(en), .trig_i(trig),
        .rate_sel_i(rate_sel), .phase_o(phase_o), .flip_o(flip_o),
        .overrun_o(overrun_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int exp_len(input logic [1:0] r, input int p);
        int integ = (r == 2'd1) ? 165 : (r == 2'd2) ? 435 : 65;
        int hold  = (r == 2'd2) ? 80 : 20;
        case (p)
            1: return 20;
            2: return integ;
            3: return 30;
            4: return integ;
            default: return hold;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(phase_o == 6'b000001, "R1", "phase during reset", phase_o, 1);
        rst = 1'b0;
        @(negedge clk);
        check(phase_o == 6'b000001, "R1", "phase after reset", phase_o, 1);
        check(flip_o == 1'b0, "R1", "flip after reset", flip_o, 0);
        check(overrun_o == 1'b0, "R1", "overrun after reset", overrun_o, 0);
    endtask

    task automatic fire(input logic [1:0] r);
        en = 1'b1;
        rate_sel = r;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // Walks one whole readout cycle from its first clear cycle, comparing every
    // cycle; an optional trigger is poked at cycle index poke_at.
    task automatic walk(input logic [1:0] r, input string req, input int poke_at,
                        input logic poke_en, input logic [1:0] poke_rate);
        int idx = 0;
        int flip_hits = 0;
        int flip_bad = 0;
        for (int p = 1; p <= 5; p++) begin
            int len = exp_len(r, p);
            int miss = 0;
            int got = 0;
            logic [5:0] expv = 6'b1 << p;
            for (int i = 0; i < len; i++) begin
                if (phase_o !== expv) begin
                    miss++;
                    got = phase_o;
                end
                if (flip_o) flip_hits++;
                if (flip_o !== (p == 3 && i == len - 1)) flip_bad++;
                if (idx == poke_at) begin
                    en = poke_en;
                    rate_sel = poke_rate;
                    trig = 1'b1;
                end
                @(negedge clk);
                trig = 1'b0;
                en = 1'b1;
                idx++;
            end
            check(miss == 0, req, $sformatf("phase %0d window mismatches", p), got, expv);
        end
        check(flip_hits == 1 && flip_bad == 0, "R7", "flip pulses per cycle", flip_hits, 1);
    endtask

    task automatic t_reset();
        do_reset();
    endtask

    task automatic t_rate(input logic [1:0] r, input string req);
        fire(r);
        walk(r, req, -1, 1'b1, r);
        check(phase_o == 6'b000001, "R2", "idle after hold", phase_o, 1);
        check(overrun_o == 1'b0, req, "no overrun in clean cycle", overrun_o, 0);
    endtask

    task automatic t_reserved_rate();
        fire(2'd3);
        walk(2'd0, "R3", -1, 1'b1, 2'd3);
        check(phase_o == 6'b000001, "R3", "idle after code-3 cycle", phase_o, 1);
    endtask

    task automatic t_overrun();
        fire(2'd0);
        walk(2'd0, "R8", 50, 1'b1, 2'd0);
        check(overrun_o == 1'b1, "R8", "overrun after early trigger", overrun_o, 1);
        repeat (10) @(negedge clk);
        check(overrun_o == 1'b1, "R8", "overrun stays set", overrun_o, 1);
        check(phase_o == 6'b000001, "R8", "no restart from early trigger", phase_o, 1);
        do_reset();
        check(overrun_o == 1'b0, "R8", "overrun cleared by reset", overrun_o, 0);
    endtask

    task automatic t_rate_change_disabled();
        fire(2'd2);
        walk(2'd2, "R10", 100, 1'b0, 2'd0);
        check(overrun_o == 1'b0, "R11", "disabled trigger sets no overrun", overrun_o, 0);
        check(phase_o == 6'b000001, "R10", "idle after slow cycle", phase_o, 1);
    endtask

    task automatic t_back_to_back();
        fire(2'd0);
        walk(2'd0, "R4", 199, 1'b1, 2'd1);
        check(phase_o == 6'b000010, "R9", "clear right after last hold", phase_o, 2);
        walk(2'd1, "R9", -1, 1'b1, 2'd1);
        check(overrun_o == 1'b0, "R9", "no overrun on final-cycle trigger", overrun_o, 0);
    endtask

    task automatic t_enable_low_idle();
        en = 1'b0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (3) @(negedge clk);
        check(phase_o == 6'b000001, "R11", "idle with enable low", phase_o, 1);
        check(overrun_o == 1'b0, "R11", "no overrun with enable low", overrun_o, 0);
        en = 1'b1;
    endtask

    initial begin
        t_reset();
        t_rate(2'd0, "R4");
        t_rate(2'd1, "R5");
        t_rate(2'd2, "R6");
        t_reserved_rate();
        t_overrun();
        t_rate_change_disabled();
        t_back_to_back();
        t_enable_low_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule